// File: doc/BRIEF.md
# Data Cache Maintenance Command Engine

This block runs cache-maintenance commands against the tag and state store of a small set-associative write-back data cache. A command carries a three-bit operation code, a flag that points it at the secondary cache, a virtual address and a physical address. The virtual address picks the set and the way. The physical address supplies the tag to compare against. Depending on the operation, the engine checks for a hit, inspects the dirty bit, pushes the victim line out on a write-back port, and then rewrites the line's tag and state. The write-back port carries the line address rebuilt from the stored tag and the set index, together with the line data read from the external data array.

The same tag store also takes ordinary line installs from the load/store path through a fill port. Hit-invalidate commands record their outcome in a hit flag. A bus error on a write-back is reported as a one-cycle store-side error. Every command ends with a one-cycle `done` pulse. A new command is accepted only while `cmd_ready` is high.

Top module: `cache_maint_engine`

## Requirements
- R1: After reset every line holds a reserved tag that no physical address can match, its state is invalid (code 0) and it is clean; `ch_flag` is 0 and `cmd_ready` is 1.
- R2: A command is accepted at a rising edge with `cmd_valid` and `cmd_ready` both high. The set is `va[OFF_W +: IDX_W]`, the way is `va[OFF_W+IDX_W +: WAY_W]` and the compare tag is `pa[PA_W-1 -: TAG_W]`. A command that needs no write-back raises `done` for exactly one cycle, in the cycle right after acceptance.
- R3: Code 0 (index write-back invalidate) writes the selected line back when it is dirty. The line is then invalidated, unless that write-back ended with a bus error, in which case the line is left unchanged.
- R4: `wb_addr` is `{stored tag, set index, zero offset}`, and `wb_data` is the `line_rdata` of the selected set and way. `wb_valid`, `wb_addr` and `wb_data` stay steady until `wb_ack`. `done` comes in the cycle of `wb_ack`.
- R5: Code 3 (create dirty exclusive) first writes back the current line if its tag differs from the compare tag and it is dirty. It then stores the compare tag with state dirty-exclusive (code 3) and keeps the line's dirty bit.
- R6: Code 4 (hit invalidate) on a tag hit invalidates the line and sets `ch_flag`. On a miss it clears `ch_flag` and leaves the line unchanged. No other command changes `ch_flag`.
- R7: Code 5 (hit write-back invalidate) writes back the line when it hits and is dirty. It then invalidates the line whether or not it hit, and whether or not the bus reported an error.
- R8: Code 6 (hit write-back) writes back the line when it hits and is dirty, and clears the dirty bit after an error-free write-back. The line stays valid with its tag.
- R9: Codes 1, 2 and 7, and any command with `cmd_l2` set, change no line, issue no write-back, leave `ch_flag` alone and complete as in R2.
- R10: A write-back acknowledged with `wb_err` raises `err_store` for exactly the cycle of `wb_ack`, together with `done`.
- R11: A fill (`fill_valid` while `cmd_ready` is high) writes the tag from `fill_pa` into the line selected by `fill_va`, sets the state to dirty-exclusive and the dirty bit to `fill_dirty`. `SETS` and `WAYS` are powers of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command accepted |
| cmd_code | input | 3 | Maintenance operation code |
| cmd_l2 | input | 1 | Command targets the secondary cache (ignored) |
| cmd_va | input | VA_W | Virtual address: set and way select |
| cmd_pa | input | PA_W | Physical address: compare tag |
| fill_valid | input | 1 | Line install request |
| fill_va | input | VA_W | Install virtual address |
| fill_pa | input | PA_W | Install physical address |
| fill_dirty | input | 1 | Dirty bit of the installed line |
| line_set | output | IDX_W | Data-array read set |
| line_way | output | WAY_W | Data-array read way |
| line_rdata | input | LINE_BYTES*8 | Data-array read data |
| wb_valid | output | 1 | Write-back request |
| wb_addr | output | PA_W | Rebuilt victim line address |
| wb_data | output | LINE_BYTES*8 | Victim line data |
| wb_ack | input | 1 | Write-back accepted by the bus |
| wb_err | input | 1 | Bus error on the acknowledged write-back |
| done | output | 1 | Command complete pulse |
| ch_flag | output | 1 | Result of the last hit-invalidate |
| err_store | output | 1 | Store-side bus error pulse |

## Verification
Each of the eight lines of the default configuration is installed with a distinct tag and with alternating dirty bits. Every operation is then issued with the matching tag, a wrong tag, and against already invalid lines, so hit-and-dirty, hit-and-clean, miss and invalid-line behaviour are told apart by whether a write-back appears and at which address. Write-backs are acknowledged both at once and after a delay, which separates the hold-until-ack behaviour from the single-cycle path. Some write-backs are acknowledged with an error to distinguish the operations that keep the line on an error from those that drop it regardless. Follow-up hit-invalidate and write-back commands make each line's resulting tag, validity and dirty bit visible at the ports.

// File: rtl/cme_pkg.sv
package cme_pkg;

    typedef enum logic [2:0] {
        OP_IDX_WBINV = 3'd0,
        OP_IDX_LDTAG = 3'd1,
        OP_IDX_STTAG = 3'd2,
        OP_CREATE_DE = 3'd3,
        OP_HIT_INV   = 3'd4,
        OP_HIT_WBINV = 3'd5,
        OP_HIT_WB    = 3'd6,
        OP_HIT_SETV  = 3'd7
    } maint_op_e;

    typedef enum logic [1:0] {
        LS_INVALID  = 2'd0,
        LS_SHARED   = 2'd1,
        LS_CLEAN_EX = 2'd2,
        LS_DIRTY_EX = 2'd3
    } line_state_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_WB   = 2'd2
    } eng_state_e;

    // What to do to the selected line once the command resolves
    typedef enum logic [1:0] {
        ACT_KEEP  = 2'd0,
        ACT_INVAL = 2'd1,
        ACT_CLEAN = 2'd2,
        ACT_RETAG = 2'd3
    } line_act_e;

    typedef struct packed {
        logic      need_wb;
        line_act_e act_ok;   // applied after no write-back or a clean one
        line_act_e act_err;  // applied after a write-back that hit a bus error
        logic      ch_we;
        logic      ch_val;
    } decision_t;

    function automatic decision_t maint_decide(maint_op_e op, logic sec,
                                               logic hit, logic dirty);
        decision_t d;
        d = '0;
        if (!sec) begin
            case (op)
                OP_IDX_WBINV: begin
                    d.need_wb = dirty;
                    d.act_ok  = ACT_INVAL;
                    d.act_err = ACT_KEEP;
                end
                OP_CREATE_DE: begin
                    d.need_wb = dirty && !hit;
                    d.act_ok  = ACT_RETAG;
                    d.act_err = ACT_RETAG;
                end
                OP_HIT_INV: begin
                    d.ch_we  = 1'b1;
                    d.ch_val = hit;
                    d.act_ok = hit ? ACT_INVAL : ACT_KEEP;
                end
                OP_HIT_WBINV: begin
                    d.need_wb = hit && dirty;
                    d.act_ok  = ACT_INVAL;
                    d.act_err = ACT_INVAL;
                end
                OP_HIT_WB: begin
                    d.need_wb = hit && dirty;
                    d.act_ok  = (hit && dirty) ? ACT_CLEAN : ACT_KEEP;
                    d.act_err = ACT_KEEP;
                end
                default: ;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/cme_tag_store.sv
module cme_tag_store
    import cme_pkg::*;
#(
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    parameter int TAG_W = 10,
    localparam int LINES  = SETS * WAYS,
    localparam int LIDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LIDX_W-1:0] rd_idx,
    output logic [TAG_W:0]    rd_tag,
    output line_state_e       rd_state,
    output logic              rd_dirty,
    input  logic              we,
    input  logic [LIDX_W-1:0] wr_idx,
    input  logic [TAG_W:0]    wr_tag,
    input  line_state_e       wr_state,
    input  logic              wr_dirty
);
    // Top tag bit set marks the reserved never-matching tag
    localparam logic [TAG_W:0] BAD_TAG = {1'b1, {TAG_W{1'b0}}};

    logic [TAG_W:0] tag_q   [LINES];
    line_state_e    state_q [LINES];
    logic           dirty_q [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q[i]   <= BAD_TAG;
                state_q[i] <= LS_INVALID;
                dirty_q[i] <= 1'b0;
            end else if (we && wr_idx == LIDX_W'(i)) begin
                tag_q[i]   <= wr_tag;
                state_q[i] <= wr_state;
                dirty_q[i] <= wr_dirty;
            end
        end
    end

    assign rd_tag   = tag_q[rd_idx];
    assign rd_state = state_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];

    // R1: an invalid line is never dirty and always holds the reserved tag
    p_invalid_clean_r1: assert property (@(posedge clk) disable iff (rst)
        rd_state == LS_INVALID |-> !rd_dirty && rd_tag[TAG_W]);

endmodule

// File: rtl/cme_line_update.sv
module cme_line_update
    import cme_pkg::*;
#(
    parameter int TAG_W = 10
) (
    input  logic             en,
    input  line_act_e        act,
    input  logic [TAG_W:0]   cur_tag,
    input  line_state_e      cur_state,
    input  logic             cur_dirty,
    input  logic [TAG_W-1:0] new_tag,
    output logic             we,
    output logic [TAG_W:0]   wr_tag,
    output line_state_e      wr_state,
    output logic             wr_dirty
);
    always_comb begin
        we       = en && (act != ACT_KEEP);
        wr_tag   = cur_tag;
        wr_state = cur_state;
        wr_dirty = cur_dirty;
        case (act)
            ACT_INVAL: begin
                wr_tag   = {1'b1, {TAG_W{1'b0}}};
                wr_state = LS_INVALID;
                wr_dirty = 1'b0;
            end
            ACT_CLEAN: wr_dirty = 1'b0;
            ACT_RETAG: begin
                wr_tag   = {1'b0, new_tag};
                wr_state = LS_DIRTY_EX;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cache_maint_engine.sv
module cache_maint_engine
    import cme_pkg::*;
#(
    parameter int SETS       = 4,
    parameter int WAYS       = 2,
    parameter int LINE_BYTES = 16,
    parameter int VA_W       = 16,
    parameter int PA_W       = 16,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(SETS),
    localparam int WAY_W     = $clog2(WAYS),
    localparam int TAG_W     = PA_W - OFF_W - IDX_W,
    localparam int LINE_BITS = LINE_BYTES * 8,
    localparam int LIDX_W    = IDX_W + WAY_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [2:0]           cmd_code,
    input  logic                 cmd_l2,
    input  logic [VA_W-1:0]      cmd_va,
    input  logic [PA_W-1:0]      cmd_pa,
    input  logic                 fill_valid,
    input  logic [VA_W-1:0]      fill_va,
    input  logic [PA_W-1:0]      fill_pa,
    input  logic                 fill_dirty,
    output logic [IDX_W-1:0]     line_set,
    output logic [WAY_W-1:0]     line_way,
    input  logic [LINE_BITS-1:0] line_rdata,
    output logic                 wb_valid,
    output logic [PA_W-1:0]      wb_addr,
    output logic [LINE_BITS-1:0] wb_data,
    input  logic                 wb_ack,
    input  logic                 wb_err,
    output logic                 done,
    output logic                 ch_flag,
    output logic                 err_store
);
    eng_state_e       st_q;
    maint_op_e        op_q;
    logic             sec_q;
    logic [IDX_W-1:0] set_q;
    logic [WAY_W-1:0] way_q;
    logic [TAG_W-1:0] ctag_q;

    logic [TAG_W:0] rd_tag;
    line_state_e    rd_state;
    logic           rd_dirty;
    logic           hit;
    decision_t      dec;
    line_act_e      act;
    logic           fire;

    logic             eng_we;
    logic [TAG_W:0]   eng_tag;
    line_state_e      eng_state;
    logic             eng_dirty;

    logic              st_we;
    logic [LIDX_W-1:0] st_idx;
    logic [TAG_W:0]    st_tag;
    line_state_e       st_state;
    logic              st_dirty;

    logic unused_addr_bits;
    assign unused_addr_bits = ^{cmd_va, cmd_pa[PA_W-TAG_W-1:0],
                                fill_va, fill_pa[PA_W-TAG_W-1:0]};

    // ---------------- command capture and sequencing ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            op_q   <= OP_IDX_WBINV;
            sec_q  <= 1'b0;
            set_q  <= '0;
            way_q  <= '0;
            ctag_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (cmd_valid) begin
                    st_q   <= ST_EVAL;
                    op_q   <= maint_op_e'(cmd_code);
                    sec_q  <= cmd_l2;
                    set_q  <= cmd_va[OFF_W +: IDX_W];
                    way_q  <= cmd_va[OFF_W+IDX_W +: WAY_W];
                    ctag_q <= cmd_pa[PA_W-1 -: TAG_W];
                end
                ST_EVAL: st_q <= dec.need_wb ? ST_WB : ST_IDLE;
                ST_WB:   if (wb_ack) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign cmd_ready = (st_q == ST_IDLE);

    // ---------------- line evaluation ----------------
    assign hit  = (rd_tag == {1'b0, ctag_q});
    assign dec  = maint_decide(op_q, sec_q, hit, rd_dirty);
    assign fire = (st_q == ST_EVAL && !dec.need_wb) || (st_q == ST_WB && wb_ack);
    assign act  = (st_q == ST_WB && wb_err) ? dec.act_err : dec.act_ok;

    cme_line_update #(.TAG_W(TAG_W)) u_update (
        .en        (fire),
        .act       (act),
        .cur_tag   (rd_tag),
        .cur_state (rd_state),
        .cur_dirty (rd_dirty),
        .new_tag   (ctag_q),
        .we        (eng_we),
        .wr_tag    (eng_tag),
        .wr_state  (eng_state),
        .wr_dirty  (eng_dirty)
    );

    // Fills own the write port while idle, the engine otherwise
    always_comb begin
        if (st_q == ST_IDLE) begin
            st_we    = fill_valid;
            st_idx   = {fill_va[OFF_W +: IDX_W], fill_va[OFF_W+IDX_W +: WAY_W]};
            st_tag   = {1'b0, fill_pa[PA_W-1 -: TAG_W]};
            st_state = LS_DIRTY_EX;
            st_dirty = fill_dirty;
        end else begin
            st_we    = eng_we;
            st_idx   = {set_q, way_q};
            st_tag   = eng_tag;
            st_state = eng_state;
            st_dirty = eng_dirty;
        end
    end

    cme_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   ({set_q, way_q}),
        .rd_tag   (rd_tag),
        .rd_state (rd_state),
        .rd_dirty (rd_dirty),
        .we       (st_we),
        .wr_idx   (st_idx),
        .wr_tag   (st_tag),
        .wr_state (st_state),
        .wr_dirty (st_dirty)
    );

    // ---------------- hit flag ----------------
    always_ff @(posedge clk) begin
        if (rst)                   ch_flag <= 1'b0;
        else if (fire && dec.ch_we) ch_flag <= dec.ch_val;
    end

    // ---------------- outputs ----------------
    assign line_set  = set_q;
    assign line_way  = way_q;
    assign wb_valid  = (st_q == ST_WB);
    assign wb_addr   = {rd_tag[TAG_W-1:0], set_q, {OFF_W{1'b0}}};
    assign wb_data   = line_rdata;
    assign done      = fire;
    assign err_store = (st_q == ST_WB) && wb_ack && wb_err;

    // ---------------- assertions ----------------
    p_wb_hold_r4: assert property (@(posedge clk) disable iff (rst)
        wb_valid && !wb_ack |=> wb_valid && $stable(wb_addr) && $stable(wb_data));

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_err_with_done_r10: assert property (@(posedge clk) disable iff (rst)
        err_store |-> done && wb_valid);

    p_ch_source_r6: assert property (@(posedge clk) disable iff (rst)
        ch_flag != $past(ch_flag) |-> $past(done) && $past(op_q) == OP_HIT_INV);

    p_busy_no_accept_r2: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> !cmd_ready);

endmodule

// File: tb/cache_maint_engine_bench.sv
module cache_maint_engine_bench;
    localparam int SETS = 4, WAYS = 2, LINE_BYTES = 16, VA_W = 16, PA_W = 16;
    localparam int OFF_W = 4, IDX_W = 2, WAY_W = 1, TAG_W = 10;
    localparam int LINE_BITS = LINE_BYTES * 8;

    logic clk = 0;
    logic rst = 1;
    logic cmd_valid = 0, cmd_l2 = 0;
    logic [2:0] cmd_code = 0;
    logic [VA_W-1:0] cmd_va = 0, fill_va = 0;
    logic [PA_W-1:0] cmd_pa = 0, fill_pa = 0;
    logic fill_valid = 0, fill_dirty = 0;
    logic wb_ack = 0, wb_err = 0;
    logic cmd_ready, wb_valid, done, ch_flag, err_store;
    logic [IDX_W-1:0] line_set;
    logic [WAY_W-1:0] line_way;
    logic [LINE_BITS-1:0] line_rdata, wb_data;
    logic [PA_W-1:0] wb_addr;

    always #10 clk = ~clk;  // 50 MHz

    assign line_rdata = {LINE_BYTES{1'b1, line_set, line_way, 4'h5}};

    cache_maint_engine u_cache_maint_engine (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_code(cmd_code), .cmd_l2(cmd_l2), .cmd_va(cmd_va), .cmd_pa(cmd_pa),
        .fill_valid(fill_valid), .fill_va(fill_va), .fill_pa(fill_pa),
        .fill_dirty(fill_dirty), .line_set(line_set), .line_way(line_way),
        .line_rdata(line_rdata), .wb_valid(wb_valid), .wb_addr(wb_addr),
        .wb_data(wb_data), .wb_ack(wb_ack), .wb_err(wb_err), .done(done),
        .ch_flag(ch_flag), .err_store(err_store)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    // bench model of the tag store
    bit mv [SETS][WAYS];
    int mt [SETS][WAYS];
    bit md [SETS][WAYS];
    bit exp_ch = 0;

    task automatic chk(input bit ok, input string rq, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
        end
    endtask

    function automatic logic [VA_W-1:0] mkva(int s, int w);
        return VA_W'((32'h1A5 << 7) | (w << 6) | (s << 4) | 32'h9);
    endfunction

    function automatic logic [PA_W-1:0] mkpa(int t);
        return PA_W'((t << 6) | 32'h2A);  // index/offset bits of pa ignored
    endfunction

    function automatic logic [LINE_BITS-1:0] expdata(int s, int w);
        logic [7:0] b;
        b = {1'b1, 2'(s), 1'(w), 4'h5};
        return {LINE_BYTES{b}};
    endfunction

    // R11: install a line through the fill port
    task automatic fill(input int s, input int w, input int t, input bit d);
        @(negedge clk);
        fill_valid = 1; fill_va = mkva(s, w); fill_pa = mkpa(t); fill_dirty = d;
        @(posedge clk); #1;
        fill_valid = 0;
        mv[s][w] = 1; mt[s][w] = t; md[s][w] = d;
    endtask

    task automatic do_cmd(input int op, input bit sec, input int s, input int w,
                          input int t, input bit e, input int dly);
        bit hit, dty, ewb, gotdone, errs, holdok;
        int n, nwb, waitc, ewaddr;
        logic [PA_W-1:0] a;
        logic [LINE_BITS-1:0] dta;
        string rq;
        hit = mv[s][w] && (mt[s][w] == t);
        dty = md[s][w];
        ewb = 0;
        ewaddr = (mt[s][w] << 6) | (s << 4);
        rq = "R9";
        if (!sec) begin
            case (op)
                0: begin rq = "R3"; ewb = dty; end
                3: begin rq = "R5"; ewb = dty && !hit; end
                4: rq = "R6";
                5: begin rq = "R7"; ewb = hit && dty; end
                6: begin rq = "R8"; ewb = hit && dty; end
                default: rq = "R9";
            endcase
        end
        // drive the command
        @(negedge clk);
        cmd_valid = 1; cmd_code = 3'(op); cmd_l2 = sec; cmd_va = mkva(s, w); cmd_pa = mkpa(t);
        @(posedge clk); #1;
        cmd_valid = 0;
        n = 0; nwb = 0; waitc = 0; gotdone = 0; errs = 0; holdok = 1; a = 0; dta = 0;
        while (!gotdone && n < 40) begin
            @(negedge clk);
            n++;
            if (wb_valid) begin
                if (nwb == 0) begin nwb = 1; a = wb_addr; dta = wb_data; end
                else if (wb_addr != a || wb_data != dta) holdok = 0;
                if (waitc == dly) begin
                    wb_ack = 1; wb_err = e;
                    #1;
                    gotdone = done; errs = err_store;
                    @(posedge clk); #1;
                    wb_ack = 0; wb_err = 0;
                end else waitc++;
            end else begin
                gotdone = done; errs = err_store;
            end
        end
        chk(gotdone, "R2", gotdone, 1);
        chk(nwb == int'(ewb), rq, nwb, ewb);
        if (!ewb) chk(n == 1, "R2", n, 1);
        if (ewb && nwb == 1) begin
            chk(a == PA_W'(ewaddr), "R4", a, ewaddr);
            chk(dta == expdata(s, w), "R4", dta[63:0], expdata(s, w));
            chk(holdok, "R4", holdok, 1);
        end
        chk(errs == (ewb && e), "R10", errs, ewb && e);
        // model update
        if (!sec) begin
            case (op)
                0: if (!(ewb && e)) begin mv[s][w] = 0; md[s][w] = 0; end
                3: begin mv[s][w] = 1; mt[s][w] = t; end
                4: begin exp_ch = hit; if (hit) begin mv[s][w] = 0; md[s][w] = 0; end end
                5: begin mv[s][w] = 0; md[s][w] = 0; end
                6: if (ewb && !e) md[s][w] = 0;
                default: ;
            endcase
        end
        @(negedge clk);
        chk(ch_flag == exp_ch, (op == 4 && !sec) ? "R6" : "R9", ch_flag, exp_ch);
    endtask

    function automatic int tg(int s, int w);
        return 3 * s + 17 * w + 100;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin mv[s][w] = 0; mt[s][w] = 0; md[s][w] = 0; end
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1: reset state
        chk(cmd_ready, "R1", cmd_ready, 1);
        chk(!ch_flag, "R1", ch_flag, 0);
        chk(!wb_valid && !done && !err_store, "R1", {wb_valid, done, err_store}, 0);
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                do_cmd(4, 0, s, w, 0, 0, 0);    // R1: reserved tag never hits
                do_cmd(0, 0, s, w, 0, 0, 0);    // R1: clean, no write-back
            end

        // R11 then R8: fill all lines, hit write-back sweep
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) fill(s, w, tg(s, w), (s + w) % 2);
        do_cmd(4, 0, 2, 1, tg(2, 1), 0, 0);
        chk(ch_flag == 1, "R11", ch_flag, 1);
        fill(2, 1, tg(2, 1), 1);
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                do_cmd(6, 0, s, w, tg(s, w) + 1, 0, 0);  // miss
                do_cmd(6, 0, s, w, tg(s, w), 0, 1);      // hit
                do_cmd(6, 0, s, w, tg(s, w), 0, 0);      // now clean
                do_cmd(4, 0, s, w, tg(s, w), 0, 0);      // R6 hit
                do_cmd(4, 0, s, w, tg(s, w), 0, 0);      // R6 miss
            end

        // R3: index write-back invalidate, delayed ack
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                fill(s, w, tg(s, w) + 7, (s + w) % 2 == 0);
                do_cmd(0, 0, s, w, 5, 0, 2);
                do_cmd(4, 0, s, w, tg(s, w) + 7, 0, 0);
            end

        // R3/R10: bus error keeps the line, retry then succeeds
        fill(1, 0, 321, 1);
        do_cmd(0, 0, 1, 0, 0, 1, 0);
        do_cmd(0, 0, 1, 0, 0, 0, 0);
        do_cmd(4, 0, 1, 0, 321, 0, 0);
        // R8: hit write-back with error keeps dirty
        fill(3, 1, 400, 1);
        do_cmd(6, 0, 3, 1, 400, 1, 1);
        do_cmd(6, 0, 3, 1, 400, 0, 0);

        // R7: hit write-back invalidate
        fill(0, 0, 50, 1);
        do_cmd(5, 0, 0, 0, 50, 0, 0);
        do_cmd(4, 0, 0, 0, 50, 0, 0);
        fill(0, 1, 51, 0);
        do_cmd(5, 0, 0, 1, 51, 0, 0);
        do_cmd(4, 0, 0, 1, 51, 0, 0);
        fill(1, 1, 52, 1);
        do_cmd(5, 0, 1, 1, 53, 0, 0);   // miss: still invalidated
        do_cmd(4, 0, 1, 1, 52, 0, 0);
        fill(2, 0, 54, 1);
        do_cmd(5, 0, 2, 0, 54, 1, 0);   // error: still invalidated
        do_cmd(4, 0, 2, 0, 54, 0, 0);

        // R5: create dirty exclusive
        fill(3, 0, 60, 1);
        do_cmd(3, 0, 3, 0, 61, 0, 0);   // write back tag 60
        do_cmd(6, 0, 3, 0, 61, 0, 0);   // dirty kept: write back tag 61
        fill(2, 1, 70, 0);
        do_cmd(3, 0, 2, 1, 71, 0, 0);   // clean: no write-back
        do_cmd(4, 0, 2, 1, 71, 0, 0);
        do_cmd(3, 0, 2, 1, 72, 0, 0);   // invalid line
        do_cmd(4, 0, 2, 1, 72, 0, 0);
        fill(1, 0, 80, 1);
        do_cmd(3, 0, 1, 0, 80, 0, 0);   // same tag: no write-back
        do_cmd(0, 0, 1, 0, 0, 0, 0);

        // R9: ignored commands on a dirty line
        fill(0, 1, 90, 1);
        do_cmd(1, 0, 0, 1, 90, 0, 0);
        do_cmd(2, 0, 0, 1, 90, 0, 0);
        do_cmd(7, 0, 0, 1, 90, 0, 0);
        do_cmd(0, 1, 0, 1, 90, 0, 0);
        do_cmd(4, 1, 0, 1, 90, 0, 0);
        do_cmd(5, 1, 0, 1, 90, 0, 0);
        do_cmd(6, 0, 0, 1, 90, 0, 0);   // line still dirty and valid

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule